// File: doc/BRIEF.md
# Three-lane 7:1 parallel serializer

This block turns a 21-bit parallel word into three serial data lanes and one forwarded frame-clock lane. It runs on a bit-rate clock that is seven times the frame rate. A 7-slot counter marks the bit positions. At each frame boundary the whole word is loaded at once into three 7-bit shift registers, one per lane. Each lane then sends its slice, highest bit first, one bit per bit clock. Frames follow each other with no gap.

The fourth lane carries the frame clock. It is high for the first four bit slots of each frame and low for the last three, so its rising edge marks bit position 0 on every data lane. A receiver rebuilds the word by using that rising edge as the frame marker.

Frame alignment comes from a single-cycle start input. The bit clock itself comes from a clock synthesizer outside the block. An active-low shutdown input clears all state and forces every output low. After shutdown is released, the block waits for a new start before it sends anything.

Top module: `ser7_tx`

## Requirements
- R1: The word on `word_i` at the load edge (the start edge, or the edge that ends slot 6) is the word sent in the frame that follows. Every word that is loaded is sent complete.
- R2: Lane 0 carries word bits 6..0, lane 1 carries bits 13..7 and lane 2 carries bits 20..14.
- R3: Each lane sends its slice highest bit first. The last bit of one frame is followed directly by the first bit of the next frame.
- R4: A frame lasts exactly 7 bit-clock cycles. While running, the slot counter counts 0 to 6 and wraps to 0.
- R5: `fclk_o` is high in slots 0 to 3 and low in slots 4 to 6. Its rising edge coincides with slot 0.
- R6: The first bit of a word (slot 0) is on the lanes in the bit-clock cycle right after the load edge. No further latency is added.
- R7: While `shdn_ni` is low, all lane outputs and `fclk_o` are low at once, and all internal state is cleared at the next clock edge. `start_i` and `word_i` have no effect during this time.
- R8: After reset or after shutdown is released, all outputs stay low until `start_i` is sampled high at a clock edge. A start pulse while frames are running has no effect on framing.
- R9: While `rst_ni` is low, all outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock (7x frame rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_ni | input | 1 | Shutdown and clear, active low |
| start_i | input | 1 | Frame-alignment pulse; when idle, loads the first word |
| word_i | input | 21 | Parallel word, sampled at each load edge |
| lane_o | output | 3 | Serial data lanes, bit l is lane l |
| fclk_o | output | 1 | Forwarded frame clock, 4 slots high and 3 slots low |

## Verification
The words tried are all zeros, all ones, a single set bit walked over all 21 positions, two alternating patterns and random values. Constant words expose a stuck lane or a stuck frame clock. The walking bit tells a wrong lane mapping, a bit reversal or an off-by-one slot apart, because each of these moves the single set bit to a different place in the recovered word. The alternating and random words check back-to-back frames, where a gap or an overlap would corrupt the neighbouring word. Shutdown is applied in the middle of a frame, with the inputs toggling while it is held. A start pulse is also applied during a run, to show that each of these either aborts cleanly or leaves framing unchanged.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned LANE_N = 3;
  localparam int unsigned BIT_N  = 7;
  localparam int unsigned HIGH_N = 4;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_e;
endpackage

// File: rtl/sertx_slot_ctr.sv
module sertx_slot_ctr
  import sertx_pkg::*;
#(
  parameter int unsigned BITS = BIT_N,
  localparam int unsigned CW = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          start_i,
  output logic [CW-1:0] slot_o,
  output logic          run_o,
  output logic          load_o
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  run_e          st_q;
  logic [CW-1:0] slot_q;

  // load at wrap while running, or on start while idle
  assign load_o = clr_ni && (((st_q == ST_RUN) && (slot_q == LAST)) ||
                             ((st_q == ST_IDLE) && start_i));
  assign slot_o = slot_q;
  assign run_o  = (st_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
    end else if (!clr_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
    end else if (load_o) begin
      st_q   <= ST_RUN;
      slot_q <= '0;
    end else if (st_q == ST_RUN) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  p_slot_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> (slot_q <= LAST));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN) && (slot_q == LAST) && clr_ni) |=> (slot_q == '0) && (st_q == ST_RUN));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (st_q == ST_IDLE) && (slot_q == '0));
  p_wait_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_IDLE) && !start_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/sertx_lane.sv
module sertx_lane
  import sertx_pkg::*;
#(
  parameter int unsigned BITS = BIT_N
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] par_i,
  output logic            ser_o
);
  logic [BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (!clr_ni) sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else              sh_q <= {sh_q[BITS-2:0], 1'b0};
  end

  // msb first
  assign ser_o = sh_q[BITS-1];

  p_load_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_i) |=> (ser_o == $past(par_i[BITS-1])));
  p_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_i) |=> (ser_o == $past(sh_q[BITS-2])));
endmodule

// File: rtl/sertx_fclk.sv
module sertx_fclk
  import sertx_pkg::*;
#(
  parameter int unsigned BITS  = BIT_N,
  parameter int unsigned HIGHS = HIGH_N,
  localparam int unsigned CW = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] slot_i,
  output logic          fclk_o
);
  localparam logic [CW-1:0] HI = CW'(HIGHS);

  assign fclk_o = run_i && (slot_i < HI);

  p_fclk_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fclk_o) |-> (slot_i == '0));
  p_fclk_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fclk_o) && run_i) |-> (slot_i == HI));
endmodule

// File: rtl/ser7_tx.sv
module ser7_tx
  import sertx_pkg::*;
#(
  parameter int unsigned LANES = LANE_N,
  parameter int unsigned BITS  = BIT_N,
  parameter int unsigned HIGHS = HIGH_N,
  localparam int unsigned CW     = $clog2(BITS),
  localparam int unsigned WORD_W = LANES * BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shdn_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [LANES-1:0]  lane_o,
  output logic              fclk_o
);
  logic [CW-1:0]    slot;
  logic             run;
  logic             load;
  logic             fclk_raw;
  logic [LANES-1:0] lane_raw;

  sertx_slot_ctr #(.BITS(BITS)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (shdn_ni),
    .start_i (start_i),
    .slot_o  (slot),
    .run_o   (run),
    .load_o  (load)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sertx_lane #(.BITS(BITS)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_ni (shdn_ni),
      .load_i (load),
      .par_i  (word_i[l*BITS +: BITS]),
      .ser_o  (lane_raw[l])
    );
  end

  sertx_fclk #(.BITS(BITS), .HIGHS(HIGHS)) u_fclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .slot_i (slot),
    .fclk_o (fclk_raw)
  );

  // shutdown forces outputs low before the clearing edge
  assign lane_o = lane_raw & {LANES{shdn_ni}};
  assign fclk_o = fclk_raw & shdn_ni;

  p_shdn_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |=> (lane_raw == '0) && !run);
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !fclk_o);
endmodule

// File: tb/ser7_tx_test.sv
module ser7_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shdn_n = 1'b1;
  logic        start = 1'b0;
  logic [20:0] word = '0;
  logic [2:0]  lane;
  logic        fclk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { logic [20:0] w; int c; } item_t;
  item_t exp_q[$];

  ser7_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .shdn_ni(shdn_n), .start_i(start),
    .word_i(word), .lane_o(lane), .fclk_o(fclk)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [20:0] pat(int k);
    if (k < 2) return '0;
    if (k < 4) return '1;
    if (k < 25) return 21'(1) << (k - 4);
    if (k < 29) return (k % 2 == 1) ? 21'h155555 : 21'h0AAAAA;
    return 21'($urandom);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [20:0] w);
    item_t it;
    word = w;
    it.w = w;
    it.c = cyc;
    exp_q.push_back(it);
  endtask

  // monitor: deserialize using fclk rising edge as frame marker
  initial begin
    bit          coll = 0;
    bit          prev = 0;
    int          idx = 0;
    int          rise_c = 0;
    int          last_rise = -1;
    bit          pat_ok = 1;
    logic [20:0] rx = '0;
    item_t       it;
    forever begin
      @(posedge clk); #1;
      if (!rst_n || !shdn_n) begin
        coll = 0; prev = 0; last_rise = -1;
        continue;
      end
      if (fclk && !prev) begin
        if (last_rise >= 0 && coll == 0)
          chk(cyc - last_rise == 7, "R4 frame length", cyc - last_rise, 7);
        coll = 1; idx = 0; rise_c = cyc; last_rise = cyc; pat_ok = 1; rx = '0;
      end
      if (coll) begin
        if (fclk != (idx < 4)) pat_ok = 0;
        for (int l = 0; l < 3; l++) rx[l*7 + 6 - idx] = lane[l];
        idx++;
        if (idx == 7) begin
          coll = 0;
          chk(pat_ok, "R5 fclk 4-high/3-low", int'(pat_ok), 1);
          if (exp_q.size() == 0) begin
            chk(0, "R1 unexpected frame", int'(rx), 0);
          end else begin
            it = exp_q.pop_front();
            chk(rx == it.w, "R1/R2/R3 word", int'(rx), int'(it.w));
            chk(rise_c == it.c + 1, "R6/R8 frame start cycle", rise_c, it.c + 1);
          end
        end
      end
      prev = fclk;
    end
  end

  task automatic run_words(int n, int base, bit poke, bit abort_mid);
    @(negedge clk); start = 1; put(pat(base));
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    for (int i = 1; i < n; i++) begin
      @(negedge clk); put(pat(base + i));
      if (poke && i == n / 2) begin
        // R8: start while running must not move framing
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
      end else begin
        repeat (6) @(negedge clk);
      end
    end
    if (abort_mid) begin
      @(negedge clk); put(pat(base + n));
      repeat (3) @(negedge clk);
      shdn_n = 0;
      exp_q.delete();
    end else begin
      @(negedge clk);
      chk(exp_q.size() == 0, "R1 all words sent", exp_q.size(), 0);
      shdn_n = 0;
    end
    #1;
    chk(lane == 3'b000 && fclk == 1'b0, "R7 outputs low at shutdown", {fclk, lane}, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    word = 21'h1FFFFF;
    start = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(lane == 3'b000 && fclk == 1'b0, "R9 reset outputs low", {fclk, lane}, 0);
    @(negedge clk); start = 0; rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk(lane == 3'b000 && fclk == 1'b0, "R8 idle after reset", {fclk, lane}, 0);

    run_words(40, 0, 0, 1);
    // R7: inputs ignored while shut down
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); start = i[0]; word = 21'($urandom);
      #1;
      chk(lane == 3'b000 && fclk == 1'b0, "R7 quiet in shutdown", {fclk, lane}, 0);
    end
    @(negedge clk); start = 0; shdn_n = 1; word = '1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk(lane == 3'b000 && fclk == 1'b0, "R8 idle until start", {fclk, lane}, 0);
    end

    run_words(30, 29, 1, 0);
    repeat (3) @(negedge clk);
    shdn_n = 1;
    repeat (5) @(negedge clk);
    #1;
    chk(lane == 3'b000 && fclk == 1'b0, "R8 idle after release", {fclk, lane}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule